// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Transmitter

This block accepts characters from a processor-side write port into a one-entry holding buffer. It hands each one to a shift engine, which serialises it onto `txd` as a low start bit, five to eight data bits, an optional parity bit and one, one-and-a-half or two high stop bits. One clock cycle of `clk` is one period of the transmit clock. Each bit lasts 1, 16 or 64 of these periods, as set by the rate selector.

The processor watches `tx_rdy` to learn when it may write the next character, and `tx_empty` to learn when the line has fallen idle. A character waits in the buffer until the transmitter is enabled, clear-to-send (`cts_n`) is low and the configuration is marked valid. A break request drives the line low for as long as it is held. The framing is chosen by plain configuration inputs. Decoding of control words happens outside this block.

Top module: `async_tx`

## Requirements
- R1: After reset, and for as long as `cfg_ok` is low, `txd` is high. No character leaves the buffer while `cfg_ok` is low, and `brk` has no effect.
- R2: `tx_rdy` is high exactly when the holding buffer is empty. It is low from the cycle after an accepted write. A write made while `tx_rdy` is low is ignored.
- R3: A frame is a 0 start bit, then `5 + len_sel` data bits least-significant first, then, when `par_en` = 1, a parity bit, then high stop bits. With `par_odd` = 0 the parity bit makes the number of ones in data plus parity even. With `par_odd` = 1 it makes that number odd.
- R4: Each bit lasts F clock cycles, where `rate_sel` 00 gives F = 1, 01 gives F = 16, and 10 or 11 gives F = 64.
- R5: `stop_sel` 00 gives one stop bit of F cycles, and 10 or 11 gives two stop bits (2F cycles). `stop_sel` 01 gives 3F/2 cycles of stop when F is 16 or 64, and two full stop bits (2 cycles) when F is 1.
- R6: A character written while the transmitter is idle and permitted to send puts its start bit on `txd` in the cycle after the write is registered.
- R7: A frame starts only when `tx_en` = 1 and `cts_n` = 0. Otherwise the character stays in the buffer, `tx_rdy` stays low and `txd` stays high.
- R8: If `cts_n` rises during a frame, that frame completes unchanged and the buffered character is held back until `cts_n` falls again.
- R9: When the buffer is full at the end of a frame, the next start bit follows the last stop period with no idle cycle.
- R10: With `cfg_ok` = 1, `brk` = 1 holds `txd` low in every cycle it is asserted.
- R11: `tx_empty` is high exactly when both the buffer and the shift engine are empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock, 1x/16x/64x the bit rate |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_ok | input | 1 | Configuration valid; line held marking while low |
| rate_sel | input | 2 | Clocks per bit: 00=1, 01=16, 1x=64 |
| len_sel | input | 2 | Data bits = 5 + len_sel |
| par_en | input | 1 | Append a parity bit |
| par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| stop_sel | input | 2 | 00=1, 01=1.5, 1x=2 stop bits |
| tx_en | input | 1 | Transmit enable |
| cts_n | input | 1 | Clear to send, active low |
| brk | input | 1 | Force continuous break (line low) |
| wr_stb | input | 1 | Write strobe for the holding buffer |
| wr_data | input | DATA_W | Character to send |
| txd | output | 1 | Serial line output |
| tx_rdy | output | 1 | Holding buffer can accept a character |
| tx_empty | output | 1 | Buffer and shift engine both empty |

## Verification
The bench builds the block with its defaults: an 8-bit character port and bit lengths of 1, 16 and 64 cycles. This brings every rate, every character length and every stop setting, including the half-bit stop, into reach of both random pairs and directed cases. The 64x rate sets the longest frames, up to 768 cycles, and so sets the run length. At 1x the half-bit stop setting falls back to two full stop bits. Each frame is compared cycle by cycle against a waveform computed from the configuration. The distance between back-to-back start edges shows both exact stop length and the absence of gaps.

// File: rtl/async_tx_pkg.sv
package async_tx_pkg;

    // Framing selection carried from the configuration ports into the framer.
    typedef struct packed {
        logic [1:0] rate;     // 00: 1x, 01: 16x, 1x: 64x
        logic [1:0] len;      // data bits = MIN_BITS + len
        logic       par_en;
        logic       par_odd;
        logic [1:0] stop;     // 00: 1, 01: 1.5, 1x: 2
    } tx_cfg_t;

endpackage

// File: rtl/async_tx_holdreg.sv
module async_tx_holdreg #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              take,
    output logic              full,
    output logic [DATA_W-1:0] data
);

    typedef struct packed {
        logic              full;
        logic [DATA_W-1:0] data;
    } hold_t;

    hold_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // take is only raised while full, so it never meets an accepted write
        if (take) begin
            st_d.full = 1'b0;
        end
        if (wr_stb && !st_q.full) begin
            st_d.full = 1'b1;
            st_d.data = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign full = st_q.full;
    assign data = st_q.data;

endmodule

// File: rtl/async_tx_framer.sv
module async_tx_framer
    import async_tx_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int MIN_BITS = 5,
    parameter int FRAME_W  = DATA_W + 4,
    parameter int BIT_W    = $clog2(FRAME_W + 1)
) (
    input  tx_cfg_t            cfg,
    input  logic [DATA_W-1:0]  data,
    output logic [FRAME_W-1:0] frame,
    output logic [BIT_W-1:0]   nbits,
    output logic               half_last
);

    int   nd;
    logic one_x;
    logic two_slots;
    logic par;

    always_comb begin
        nd        = MIN_BITS + int'(cfg.len);
        one_x     = (cfg.rate == 2'b00);
        two_slots = (cfg.stop != 2'b00);
        half_last = (cfg.stop == 2'b01) && !one_x;
        par       = cfg.par_odd;
        frame     = '1;
        frame[0]  = 1'b0;
        for (int i = 0; i < DATA_W; i++) begin
            if (i < nd) begin
                frame[i+1] = data[i];
                par        = par ^ data[i];
            end
        end
        for (int j = 0; j < FRAME_W; j++) begin
            if (cfg.par_en && (j == nd + 1)) begin
                frame[j] = par;
            end
        end
        nbits = BIT_W'(1 + nd + (cfg.par_en ? 1 : 0) + (two_slots ? 2 : 1));
    end

endmodule

// File: rtl/async_tx_shifter.sv
module async_tx_shifter #(
    parameter int FRAME_W = 12,
    parameter int BIT_W   = 4,
    parameter int LEN_W   = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [FRAME_W-1:0] frame_in,
    input  logic [BIT_W-1:0]   nbits_in,
    input  logic               half_in,
    input  logic [LEN_W-1:0]   bitlen_in,
    output logic               active,
    output logic               cur_bit,
    output logic               last_cycle
);

    typedef struct packed {
        logic               active;
        logic [FRAME_W-1:0] frame;
        logic [BIT_W-1:0]   left;
        logic [LEN_W-1:0]   tick;
        logic [LEN_W-1:0]   bitlen;
        logic               half;
    } shf_t;

    shf_t st_d, st_q;

    assign last_cycle = st_q.active && (st_q.tick == '0) && (st_q.left == BIT_W'(1));

    always_comb begin
        st_d = st_q;
        if (st_q.active) begin
            if (st_q.tick != '0) begin
                st_d.tick = st_q.tick - LEN_W'(1);
            end else if (st_q.left != BIT_W'(1)) begin
                st_d.frame = {1'b1, st_q.frame[FRAME_W-1:1]};
                st_d.left  = st_q.left - BIT_W'(1);
                st_d.tick  = (st_q.left == BIT_W'(2) && st_q.half)
                           ? (st_q.bitlen >> 1) - LEN_W'(1)
                           : st_q.bitlen - LEN_W'(1);
            end else begin
                st_d.active = 1'b0;
            end
        end
        if (load) begin
            st_d.active = 1'b1;
            st_d.frame  = frame_in;
            st_d.left   = nbits_in;
            st_d.tick   = bitlen_in - LEN_W'(1);
            st_d.bitlen = bitlen_in;
            st_d.half   = half_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.frame <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign active  = st_q.active;
    assign cur_bit = st_q.frame[0];

endmodule

// File: rtl/async_tx.sv
module async_tx
    import async_tx_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int MIN_BITS = 5,
    parameter int FAC_MID  = 16,
    parameter int FAC_HI   = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_ok,
    input  logic [1:0]        rate_sel,
    input  logic [1:0]        len_sel,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic [1:0]        stop_sel,
    input  logic              tx_en,
    input  logic              cts_n,
    input  logic              brk,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    output logic              txd,
    output logic              tx_rdy,
    output logic              tx_empty
);

    localparam int CNT_W   = $clog2(FAC_HI);
    localparam int LEN_W   = CNT_W + 1;
    localparam int FRAME_W = DATA_W + 4;
    localparam int BIT_W   = $clog2(FRAME_W + 1);

    tx_cfg_t            cfg;
    logic               hold_full;
    logic [DATA_W-1:0]  hold_data;
    logic [FRAME_W-1:0] frame;
    logic [BIT_W-1:0]   nbits;
    logic               half_last;
    logic [LEN_W-1:0]   bitlen;
    logic               sh_active;
    logic               sh_bit;
    logic               sh_last;
    logic               load;

    assign cfg = '{rate: rate_sel, len: len_sel, par_en: par_en,
                   par_odd: par_odd, stop: stop_sel};

    always_comb begin
        case (rate_sel)
            2'b00:   bitlen = LEN_W'(1);
            2'b01:   bitlen = LEN_W'(FAC_MID);
            default: bitlen = LEN_W'(FAC_HI);
        endcase
    end

    // gating is checked only at a frame boundary, so a running frame always completes
    assign load = cfg_ok && tx_en && !cts_n && hold_full && (!sh_active || sh_last);

    async_tx_holdreg #(.DATA_W(DATA_W)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_stb  (wr_stb),
        .wr_data (wr_data),
        .take    (load),
        .full    (hold_full),
        .data    (hold_data)
    );

    async_tx_framer #(
        .DATA_W   (DATA_W),
        .MIN_BITS (MIN_BITS),
        .FRAME_W  (FRAME_W),
        .BIT_W    (BIT_W)
    ) u_framer (
        .cfg       (cfg),
        .data      (hold_data),
        .frame     (frame),
        .nbits     (nbits),
        .half_last (half_last)
    );

    async_tx_shifter #(
        .FRAME_W (FRAME_W),
        .BIT_W   (BIT_W),
        .LEN_W   (LEN_W)
    ) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .frame_in   (frame),
        .nbits_in   (nbits),
        .half_in    (half_last),
        .bitlen_in  (bitlen),
        .active     (sh_active),
        .cur_bit    (sh_bit),
        .last_cycle (sh_last)
    );

    assign txd      = !cfg_ok ? 1'b1 : (brk ? 1'b0 : (sh_active ? sh_bit : 1'b1));
    assign tx_rdy   = !hold_full;
    assign tx_empty = !hold_full && !sh_active;

endmodule

// File: rtl/async_tx_chk.sv
module async_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic cfg_ok,
    input logic tx_en,
    input logic cts_n,
    input logic brk,
    input logic wr_stb,
    input logic txd,
    input logic tx_rdy,
    input logic tx_empty
);

    a_r2_write_fills: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb && tx_rdy |=> !tx_rdy);

    a_r7_start_gated: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_rdy) |-> $past(tx_en && !cts_n && cfg_ok));

    a_r11_empty_ready: assert property (@(posedge clk) disable iff (!rst_n)
        tx_empty |-> tx_rdy);

    a_r10_break_low: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_ok && brk |-> !txd);

    a_r1_unconfigured_mark: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_ok |-> txd);

    a_r3_idle_mark: assert property (@(posedge clk) disable iff (!rst_n)
        tx_empty && !brk |-> txd);

endmodule

bind async_tx async_tx_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_ok   (cfg_ok),
    .tx_en    (tx_en),
    .cts_n    (cts_n),
    .brk      (brk),
    .wr_stb   (wr_stb),
    .txd      (txd),
    .tx_rdy   (tx_rdy),
    .tx_empty (tx_empty)
);

// File: tb/tb_async_tx.sv
module tb_async_tx;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_ok = 1'b0;
    logic [1:0] rate_sel = 2'b00;
    logic [1:0] len_sel = 2'b11;
    logic       par_en = 1'b0;
    logic       par_odd = 1'b0;
    logic [1:0] stop_sel = 2'b00;
    logic       tx_en = 1'b0;
    logic       cts_n = 1'b1;
    logic       brk = 1'b0;
    logic       wr_stb = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       txd, tx_rdy, tx_empty;

    int cyc = 0;
    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #2 clk = ~clk;
    always_ff @(posedge clk) cyc <= cyc + 1;

    async_tx dut (
        .clk(clk), .rst_n(rst_n), .cfg_ok(cfg_ok), .rate_sel(rate_sel),
        .len_sel(len_sel), .par_en(par_en), .par_odd(par_odd), .stop_sel(stop_sel),
        .tx_en(tx_en), .cts_n(cts_n), .brk(brk), .wr_stb(wr_stb), .wr_data(wr_data),
        .txd(txd), .tx_rdy(tx_rdy), .tx_empty(tx_empty)
    );

    task automatic check_eq(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int fac_of();
        return (rate_sel == 2'b00) ? 1 : ((rate_sel == 2'b01) ? 16 : 64);
    endfunction

    function automatic int stop_cyc();
        int f = fac_of();
        if (stop_sel == 2'b00) return f;
        if (stop_sel == 2'b01) return (f == 1) ? 2 : (f * 3) / 2;
        return 2 * f;
    endfunction

    function automatic int frame_cyc();
        return fac_of() * (1 + 5 + int'(len_sel) + (par_en ? 1 : 0)) + stop_cyc();
    endfunction

    function automatic logic exp_level(logic [7:0] d, int k);
        int   n  = 5 + int'(len_sel);
        int   bi = k / fac_of();
        logic p  = par_odd;
        for (int i = 0; i < 8; i++) if (i < n) p = p ^ d[i];
        if (bi == 0) return 1'b0;
        if (bi <= n) return d[bi-1];
        if (par_en && bi == n + 1) return p;
        return 1'b1;
    endfunction

    task automatic do_write(logic [7:0] d, output int wcyc);
        int w = 0;
        @(negedge clk);
        while (!tx_rdy && w < 6000) begin
            @(negedge clk);
            w++;
        end
        wr_stb  = 1'b1;
        wr_data = d;
        @(negedge clk);
        wcyc   = cyc;
        wr_stb = 1'b0;
    endtask

    // Waits for a start bit, then compares the whole frame cycle by cycle.
    task automatic capture(logic [7:0] d, output int t0, output int bad);
        int w = 0;
        int len = frame_cyc();
        bad = 0;
        @(negedge clk);
        while (txd !== 1'b0 && w < 6000) begin
            @(negedge clk);
            w++;
        end
        t0 = cyc;
        if (w >= 6000) bad = 999;
        for (int k = 0; k < len; k++) begin
            if (k > 0) @(negedge clk);
            if (txd !== exp_level(d, k)) bad++;
        end
    endtask

    task automatic hold_quiet(int ncyc, output int nlow);
        nlow = 0;
        for (int k = 0; k < ncyc; k++) begin
            @(negedge clk);
            if (txd !== 1'b1) nlow++;
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end

    initial begin
        int wc, t0, t1, b0, b1, nl;
        logic [7:0] a, b;
        void'($urandom(32'd7));
        brk = 1'b1;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 / R2 / R11 reset state
        check_eq("R1", "txd after reset", txd, 1);
        check_eq("R2", "tx_rdy after reset", tx_rdy, 1);
        check_eq("R11", "tx_empty after reset", tx_empty, 1);

        // R1: unconfigured, break and enable ignored, char stays buffered
        tx_en = 1'b1; cts_n = 1'b0;
        do_write(8'hA5, wc);
        hold_quiet(50, nl);
        check_eq("R1", "low cycles while unconfigured", nl, 0);
        check_eq("R1", "tx_empty while unconfigured", tx_empty, 0);
        brk = 1'b0;
        fork
            begin cfg_ok = 1'b1; end
            capture(8'hA5, t0, b0);
        join
        check_eq("R3", "frame A5 8N1 1x", b0, 0);
        @(negedge clk);
        check_eq("R11", "tx_empty after frame", tx_empty, 1);

        // R6 latency at 16x, with even parity
        rate_sel = 2'b01; len_sel = 2'b11; par_en = 1'b1; par_odd = 1'b0; stop_sel = 2'b00;
        fork
            do_write(8'h3C, wc);
            capture(8'h3C, t0, b0);
        join
        check_eq("R6", "start latency", t0 - wc, 1);
        check_eq("R3", "frame 3C 8E1 16x", b0, 0);
        check_eq("R11", "tx_empty late in stop", tx_empty, 0);
        @(negedge clk);
        check_eq("R11", "tx_empty exactly after stop", tx_empty, 1);

        // R5 half stop at 16x and 64x, R9 back-to-back spacing
        for (int r = 1; r <= 2; r++) begin
            rate_sel = 2'(r); len_sel = 2'b00; par_en = 1'b0; stop_sel = 2'b01;
            fork
                begin do_write(8'h15, wc); do_write(8'h0A, wc); end
                begin capture(8'h15, t0, b0); capture(8'h0A, t1, b1); end
            join
            check_eq("R5", "1.5 stop spacing", t1 - t0, fac_of() * 6 + fac_of() * 3 / 2);
            check_eq("R3", "5N1.5 frames", b0 + b1, 0);
        end
        // R5 at 1x: 01 gives two full stops
        rate_sel = 2'b00; stop_sel = 2'b01;
        fork
            begin do_write(8'h1F, wc); do_write(8'h00, wc); end
            begin capture(8'h1F, t0, b0); capture(8'h00, t1, b1); end
        join
        check_eq("R5", "1x half-stop fallback spacing", t1 - t0, 8);
        check_eq("R4", "1x frames", b0 + b1, 0);

        // R7 gated by cts_n and by tx_en
        rate_sel = 2'b01; len_sel = 2'b11; par_en = 1'b0; stop_sel = 2'b00;
        cts_n = 1'b1;
        do_write(8'h96, wc);
        hold_quiet(100, nl);
        check_eq("R7", "line quiet while cts_n high", nl, 0);
        check_eq("R7", "tx_rdy while cts_n high", tx_rdy, 0);
        fork
            begin @(negedge clk); cts_n = 1'b0; end
            capture(8'h96, t0, b0);
        join
        check_eq("R7", "frame after cts_n falls", b0, 0);
        tx_en = 1'b0;
        do_write(8'h69, wc);
        hold_quiet(100, nl);
        check_eq("R7", "line quiet while tx_en low", nl, 0);
        fork
            begin @(negedge clk); tx_en = 1'b1; end
            capture(8'h69, t0, b0);
        join
        check_eq("R7", "frame after tx_en rises", b0, 0);

        // R2 write while full ignored
        cts_n = 1'b1;
        repeat (20) @(negedge clk);
        do_write(8'hC3, wc);
        wr_stb = 1'b1; wr_data = 8'h5A;
        @(negedge clk);
        wr_stb = 1'b0;
        check_eq("R2", "tx_rdy stays low", tx_rdy, 0);
        fork
            begin @(negedge clk); cts_n = 1'b0; end
            capture(8'hC3, t0, b0);
        join
        check_eq("R2", "first char kept", b0, 0);
        @(negedge clk);
        check_eq("R2", "second write dropped (empty)", tx_empty, 1);

        // R8 cts_n rises mid-frame
        fork
            begin do_write(8'hE1, wc); do_write(8'h7E, wc); repeat (20) @(negedge clk); cts_n = 1'b1; end
            capture(8'hE1, t0, b0);
        join
        check_eq("R8", "frame completes after cts_n rise", b0, 0);
        hold_quiet(100, nl);
        check_eq("R8", "next char held", nl, 0);
        check_eq("R8", "tx_empty while held", tx_empty, 0);
        fork
            begin @(negedge clk); cts_n = 1'b0; end
            capture(8'h7E, t0, b0);
        join
        check_eq("R8", "held char sent", b0, 0);

        // R10 break
        repeat (5) @(negedge clk);
        brk = 1'b1;
        nl = 0;
        for (int k = 0; k < 50; k++) begin
            @(negedge clk);
            if (txd !== 1'b0) nl++;
        end
        check_eq("R10", "high cycles during break", nl, 0);
        brk = 1'b0;
        @(negedge clk);
        check_eq("R10", "line after break", txd, 1);

        // Random pairs: R3 R4 R5 R9
        for (int it = 0; it < 24; it++) begin
            rate_sel = 2'($urandom_range(0, 3));
            len_sel  = 2'($urandom_range(0, 3));
            par_en   = 1'($urandom_range(0, 1));
            par_odd  = 1'($urandom_range(0, 1));
            stop_sel = 2'($urandom_range(0, 3));
            a = 8'($urandom);
            b = 8'($urandom);
            @(negedge clk);
            fork
                begin do_write(a, wc); do_write(b, wc); end
                begin capture(a, t0, b0); capture(b, t1, b1); end
            join
            check_eq("R3", "random frame pair", b0 + b1, 0);
            check_eq("R9", "random back-to-back spacing (R4 R5)", t1 - t0, frame_cyc());
            @(negedge clk);
            check_eq("R11", "random tx_empty after pair", tx_empty, 1);
        end

        done = 1;
        summary();
    end

endmodule